// File: doc/BRIEF.md
# I2C SCL Clock Timing Generator

This block produces the serial clock timing for an I2C master. A timing setting made of three fields sets the SCL period: a base exponent that prescales the system clock by a power of two, a high-phase count and a low-phase count. Each count is stored as one less than the number of prescaled ticks its phase lasts. While enabled, the block drives a raw SCL level and two one-cycle strobes, one at the start of each low phase and one at the start of each high phase. A master sequencer uses these strobes to move SDA. New settings are picked up only when one period ends and the next begins.

The block also contains a combinational solver. It turns a requested total divisor (system clock over bus clock, rounded up) into the three fields. It picks the smallest base exponent that lets the counts reach the divisor. It then splits the prescaled divisor roughly evenly, giving the extra tick to the high phase. If even the largest exponent is too small, it clamps every field to its maximum.

Top module: `scl_timing_gen`

## Requirements
- R1: While `rst` is high, `scl_o` is 1 and `hi_tick` and `lo_tick` are 0 one cycle later.
- R2: While `en` is low, `scl_o` is 1 and neither strobe pulses. After `en` rises, the next period starts with a low phase.
- R3: A low phase lasts (lo+1)·2^base system clock cycles, with `scl_o` at 0 throughout.
- R4: A high phase lasts (hi+1)·2^base cycles, with `scl_o` at 1 throughout. `hi_tick` pulses for one cycle in its first cycle.
- R5: `lo_tick` pulses for one cycle in the first cycle of each low phase. It repeats every (hi+lo+2)·2^base cycles, and the two strobes never pulse together.
- R6: The timing fields are sampled only when a period starts: at enable, or at the cycle in which `lo_tick` is registered. A change in the middle of a period does not alter that period.
- R7: The solver returns base 0 when the divisor is at most 2·2^CNT_W. Otherwise it returns floor(log2((div−1)/(2·2^CNT_W)))+1.
- R8: When the base fits, the solver computes t = ceil(div/2^base). It sets low = floor(t/2) and high = t − low, and then subtracts one from each of these that is nonzero.
- R9: If the required base exceeds 2^BASE_W−1, the solver returns that maximum base and all-ones high and low counts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run the SCL generator |
| cfg_hi | input | CNT_W | High-phase count minus one |
| cfg_lo | input | CNT_W | Low-phase count minus one |
| cfg_base | input | BASE_W | Prescaler exponent |
| req_div | input | DIV_W | Requested total divisor for the solver |
| hi_tick | output | 1 | Strobe in the first cycle of a high phase |
| lo_tick | output | 1 | Strobe in the first cycle of a low phase |
| scl_o | output | 1 | Raw SCL level |
| sol_hi | output | CNT_W | Solved high count |
| sol_lo | output | CNT_W | Solved low count |
| sol_base | output | BASE_W | Solved prescaler exponent |

## Verification
The timing outputs are registered, so a period's first `lo_tick` and falling `scl_o` appear in the cycle after the clock edge that sampled `en` high. From there, every output is a function of the cycle offset inside the period. The bench keeps a model of the period position that it advances on each rising edge, and compares the outputs against it on the falling edge, half a cycle after they settle. The solver is purely combinational: the bench drives `req_div` and reads the three fields 1 ns later, in the same cycle.

// File: rtl/scl_timing_pkg.sv
package scl_timing_pkg;
  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } scl_phase_e;
endpackage

// File: rtl/scl_prescaler.sv
module scl_prescaler #(
  parameter int BASE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic [BASE_W-1:0] base,
  output logic              base_tick
);
  localparam int PRE_W = 1 << BASE_W;

  logic [PRE_W-1:0] pcnt;
  logic [PRE_W-1:0] mask;

  assign mask      = (PRE_W'(1) << base) - PRE_W'(1);
  assign base_tick = (pcnt == mask);

  always_ff @(posedge clk) begin
    if (rst || clr)     pcnt <= '0;
    else if (base_tick) pcnt <= '0;
    else                pcnt <= pcnt + PRE_W'(1);
  end

  // R3: prescaler count never passes the selected terminal value
  p_no_overflow_r3: assert property (@(posedge clk) disable iff (rst)
    pcnt <= mask);
endmodule

// File: rtl/scl_phase_seq.sv
module scl_phase_seq
  import scl_timing_pkg::*;
#(
  parameter int CNT_W  = 4,
  parameter int BASE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              base_tick,
  input  logic [CNT_W-1:0]  cfg_hi,
  input  logic [CNT_W-1:0]  cfg_lo,
  input  logic [BASE_W-1:0] cfg_base,
  output logic [BASE_W-1:0] act_base,
  output logic              pre_clr,
  output logic              hi_tick,
  output logic              lo_tick,
  output logic              scl_o
);
  scl_phase_e       phase;
  logic             running;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] act_hi;
  logic [CNT_W-1:0] act_lo;
  logic [CNT_W-1:0] len_m1;
  logic             phase_end;
  logic             start;

  assign len_m1    = (phase == PH_LOW) ? act_lo : act_hi;
  assign phase_end = running && base_tick && (cnt == len_m1);
  assign start     = en && (!running || (phase_end && phase == PH_HIGH));
  assign pre_clr   = !en || !running || phase_end;

  always_ff @(posedge clk) begin
    if (rst) begin
      running  <= 1'b0;
      phase    <= PH_LOW;
      cnt      <= '0;
      scl_o    <= 1'b1;
      hi_tick  <= 1'b0;
      lo_tick  <= 1'b0;
      act_hi   <= '0;
      act_lo   <= '0;
      act_base <= '0;
    end else if (!en) begin
      running <= 1'b0;
      phase   <= PH_LOW;
      cnt     <= '0;
      scl_o   <= 1'b1;
      hi_tick <= 1'b0;
      lo_tick <= 1'b0;
    end else begin
      hi_tick <= 1'b0;
      lo_tick <= 1'b0;
      if (start) begin
        running  <= 1'b1;
        phase    <= PH_LOW;
        cnt      <= '0;
        scl_o    <= 1'b0;
        lo_tick  <= 1'b1;
        act_hi   <= cfg_hi;
        act_lo   <= cfg_lo;
        act_base <= cfg_base;
      end else if (phase_end) begin
        phase   <= PH_HIGH;
        cnt     <= '0;
        scl_o   <= 1'b1;
        hi_tick <= 1'b1;
      end else if (running && base_tick) begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end

  p_ticks_exclusive_r5: assert property (@(posedge clk) disable iff (rst)
    !(hi_tick && lo_tick));

  p_idle_released_r2: assert property (@(posedge clk) disable iff (rst)
    !en |=> (scl_o && !hi_tick && !lo_tick));

  p_hi_tick_rise_r4: assert property (@(posedge clk) disable iff (rst)
    hi_tick |-> (scl_o && !$past(scl_o)));

  p_cfg_boundary_r6: assert property (@(posedge clk) disable iff (rst)
    (running && (act_hi != $past(act_hi) || act_lo != $past(act_lo))) |-> lo_tick);
endmodule

// File: rtl/scl_div_solver.sv
module scl_div_solver #(
  parameter int CNT_W  = 4,
  parameter int BASE_W = 4,
  parameter int DIV_W  = 24
) (
  input  logic [DIV_W-1:0]  req_div,
  output logic [CNT_W-1:0]  sol_hi,
  output logic [CNT_W-1:0]  sol_lo,
  output logic [BASE_W-1:0] sol_base
);
  localparam int SPAN_SH  = CNT_W + 1;
  localparam int BASE_MAX = (1 << BASE_W) - 1;
  localparam logic [DIV_W-1:0] SPAN = DIV_W'(1) << SPAN_SH;

  logic [DIV_W-1:0] q;
  logic [DIV_W:0]   t;
  logic [DIV_W:0]   half_lo;
  logic [DIV_W:0]   half_hi;
  int               msb;
  int               need;

  always_comb begin
    q   = (req_div - DIV_W'(1)) >> SPAN_SH;
    msb = 0;
    for (int i = 0; i < DIV_W; i++)
      if (q[i]) msb = i;
    need    = (req_div > SPAN) ? msb + 1 : 0;
    t       = '0;
    half_lo = '0;
    half_hi = '0;
    if (need > BASE_MAX) begin
      sol_base = BASE_W'(BASE_MAX);
      sol_hi   = '1;
      sol_lo   = '1;
    end else begin
      t       = ({1'b0, req_div} + ((DIV_W+1)'(1) << need) - (DIV_W+1)'(1)) >> need;
      half_lo = t >> 1;
      half_hi = t - half_lo;
      if (half_hi != '0) half_hi = half_hi - (DIV_W+1)'(1);
      if (half_lo != '0) half_lo = half_lo - (DIV_W+1)'(1);
      sol_base = BASE_W'(need);
      sol_hi   = half_hi[CNT_W-1:0];
      sol_lo   = half_lo[CNT_W-1:0];
    end
  end
endmodule

// File: rtl/scl_timing_gen.sv
module scl_timing_gen #(
  parameter int CNT_W  = 4,
  parameter int BASE_W = 4,
  parameter int DIV_W  = 24
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [CNT_W-1:0]  cfg_hi,
  input  logic [CNT_W-1:0]  cfg_lo,
  input  logic [BASE_W-1:0] cfg_base,
  input  logic [DIV_W-1:0]  req_div,
  output logic              hi_tick,
  output logic              lo_tick,
  output logic              scl_o,
  output logic [CNT_W-1:0]  sol_hi,
  output logic [CNT_W-1:0]  sol_lo,
  output logic [BASE_W-1:0] sol_base
);
  logic              base_tick;
  logic              pre_clr;
  logic [BASE_W-1:0] act_base;

  scl_prescaler #(.BASE_W(BASE_W)) u_pre (
    .clk       (clk),
    .rst       (rst),
    .clr       (pre_clr),
    .base      (act_base),
    .base_tick (base_tick)
  );

  scl_phase_seq #(.CNT_W(CNT_W), .BASE_W(BASE_W)) u_seq (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .base_tick (base_tick),
    .cfg_hi    (cfg_hi),
    .cfg_lo    (cfg_lo),
    .cfg_base  (cfg_base),
    .act_base  (act_base),
    .pre_clr   (pre_clr),
    .hi_tick   (hi_tick),
    .lo_tick   (lo_tick),
    .scl_o     (scl_o)
  );

  scl_div_solver #(.CNT_W(CNT_W), .BASE_W(BASE_W), .DIV_W(DIV_W)) u_sol (
    .req_div  (req_div),
    .sol_hi   (sol_hi),
    .sol_lo   (sol_lo),
    .sol_base (sol_base)
  );
endmodule

// File: tb/scl_timing_gen_test.sv
module scl_timing_gen_test;
  localparam int CW = 4;
  localparam int BW = 4;
  localparam int DW = 24;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst = 1'b1;
  logic          en = 1'b0;
  logic [CW-1:0] cfg_hi = '0;
  logic [CW-1:0] cfg_lo = '0;
  logic [BW-1:0] cfg_base = '0;
  logic [DW-1:0] req_div = '0;
  logic          hi_tick, lo_tick, scl_o;
  logic [CW-1:0] sol_hi, sol_lo;
  logic [BW-1:0] sol_base;

  scl_timing_gen #(.CNT_W(CW), .BASE_W(BW), .DIV_W(DW)) uut (
    .clk(clk), .rst(rst), .en(en), .cfg_hi(cfg_hi), .cfg_lo(cfg_lo),
    .cfg_base(cfg_base), .req_div(req_div), .hi_tick(hi_tick),
    .lo_tick(lo_tick), .scl_o(scl_o), .sol_hi(sol_hi), .sol_lo(sol_lo),
    .sol_base(sol_base)
  );

  int  vec = 0;
  int  bad = 0;
  bit  done = 0;
  bit  chk_on = 0;
  bit  r6_mode = 0;

  task automatic chk(string req, int act, int exp, string what);
    vec++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
    end
  endtask

  // period-position model
  bit m_run = 0;
  int m_pos = 0;
  int mh = 0, ml = 0, mb = 0;
  bit e_scl = 1, e_hi = 0, e_lo = 0, e_rst = 1;
  always @(posedge clk) begin
    int per, lowlen;
    per = (mh + ml + 2) << mb;
    if (rst || !en) begin
      m_run = 0; m_pos = 0;
    end else if (!m_run || m_pos == per - 1) begin
      m_run = 1; m_pos = 0;
      mh = int'(cfg_hi); ml = int'(cfg_lo); mb = int'(cfg_base);
    end else begin
      m_pos++;
    end
    lowlen = (ml + 1) << mb;
    e_rst = rst;
    e_scl = !m_run || (m_pos >= lowlen);
    e_lo  = m_run && (m_pos == 0);
    e_hi  = m_run && (m_pos == lowlen);
  end

  always @(negedge clk) begin
    if (chk_on && !done) begin
      if (e_rst) begin
        chk("R1", scl_o, 1, "scl in reset");
        chk("R1", hi_tick, 0, "hi_tick in reset");
        chk("R1", lo_tick, 0, "lo_tick in reset");
      end else if (!m_run) begin
        chk("R2", scl_o, 1, "scl idle");
        chk("R2", hi_tick + 2 * lo_tick, 0, "strobes idle");
      end else if (r6_mode) begin
        chk("R6", scl_o, e_scl, "scl after cfg change");
        chk("R6", lo_tick, e_lo, "lo_tick after cfg change");
        chk("R6", hi_tick, e_hi, "hi_tick after cfg change");
      end else begin
        chk(e_scl ? "R4" : "R3", scl_o, e_scl, "scl level");
        chk("R5", lo_tick, e_lo, "lo_tick");
        chk("R4", hi_tick, e_hi, "hi_tick");
      end
    end
  end

  task automatic run(int h, int l, int b, int n);
    @(negedge clk);
    cfg_hi = CW'(h); cfg_lo = CW'(l); cfg_base = BW'(b); en = 1'b1;
    repeat (n) @(negedge clk);
    en = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  function automatic void ref_solve(input longint d, output int rh, output int rl, output int rb);
    longint span, q, t;
    int lg;
    span = longint'(1) << (CW + 1);
    if (d <= span) rb = 0;
    else begin
      q = (d - 1) / span; lg = 0;
      while (q > 1) begin q = q / 2; lg++; end
      rb = lg + 1;
    end
    if (rb > (1 << BW) - 1) begin
      rb = (1 << BW) - 1; rh = (1 << CW) - 1; rl = (1 << CW) - 1;
    end else begin
      t = (d + (longint'(1) << rb) - 1) / (longint'(1) << rb);
      rl = int'(t / 2); rh = int'(t) - rl;
      if (rh > 0) rh--;
      if (rl > 0) rl--;
    end
  endfunction

  task automatic sol(longint d);
    int rh, rl, rb;
    req_div = DW'(d);
    #1;
    ref_solve(d, rh, rl, rb);
    if (d > ((longint'(1) << (CW + 1)) << ((1 << BW) - 1))) begin
      chk("R9", sol_base, rb, "clamped base");
      chk("R9", sol_hi, rh, "clamped hi");
      chk("R9", sol_lo, rl, "clamped lo");
    end else begin
      chk("R7", sol_base, rb, "solved base");
      chk("R8", sol_hi, rh, "solved hi");
      chk("R8", sol_lo, rl, "solved lo");
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4711));
    @(posedge clk);
    chk_on = 1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);
    // directed timing corners
    run(0, 0, 0, 20);
    run(15, 15, 0, 70);
    run(15, 15, 2, 300);
    run(3, 9, 1, 60);
    run(0, 15, 3, 300);
    // random timing settings
    for (int k = 0; k < 20; k++) begin
      int h, l, b;
      h = int'($urandom % 16); l = int'($urandom % 16); b = int'($urandom % 4);
      run(h, l, b, 2 * ((h + l + 2) << b) + 5);
    end
    // R6: mid-period change waits for the period boundary
    r6_mode = 1;
    @(negedge clk);
    cfg_hi = 4'd2; cfg_lo = 4'd5; cfg_base = 4'd1; en = 1'b1;
    repeat (7) @(negedge clk);
    cfg_hi = 4'd7; cfg_lo = 4'd1; cfg_base = 4'd0;
    repeat (60) @(negedge clk);
    en = 1'b0;
    repeat (4) @(negedge clk);
    r6_mode = 0;
    // solver corners: R7 base choice, R8 split, R9 clamp
    sol(0); sol(1); sol(2); sol(20); sol(31); sol(32); sol(33); sol(64); sol(65);
    sol(1000); sol(longint'(32) << 15); sol((longint'(32) << 15) + 1);
    sol((longint'(1) << DW) - 1);
    for (int k = 0; k < 200; k++) sol(longint'($urandom % (1 << 22)));
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end
endmodule